// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block gathers relative pointer motion and the state of three buttons and turns them into five-byte serial mouse packets. Motion events carry a signed delta and an axis select; horizontal deltas are added to the X accumulator unchanged, while vertical deltas are added to the Y accumulator with the sign flipped. Button events name one of three buttons and say whether it went down or up. Any such event also sets a pending-change flag.

When the sync strobe arrives and there is something to report, the encoder takes a snapshot and writes the five packet bytes into a byte FIFO, one byte per clock. Nothing to report means both accumulators are zero and the change flag is clear. The first byte is a start byte with the button state folded in active-low. The next two carry the X and Y motion, each clamped to plus or minus 127. Two zero bytes end the packet. Motion beyond the clamp stays in the accumulator for the next packet. The FIFO drains towards a receive channel through a valid/ready handshake and drops bytes that arrive while it is full.

Top module: `mouse_pkt_enc`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0. Both accumulators, the button mask and the change flag are cleared, so a sync with no events before it emits nothing.
- R2: A motion event with `mot_axis`=0 adds `mot_delta` to X. A motion event with `mot_axis`=1 adds the negated `mot_delta` to Y.
- R3: Each accumulator is 12-bit signed. It saturates at +2047 and -2048 and does not wrap.
- R4: A sync when both accumulators are zero and the change flag is clear writes no bytes.
- R5: A packet is five bytes in this order: 0x87 XOR the button mask, the X amount, the Y amount (both two's complement), 0x00, 0x00.
- R6: `btn_sel` 0 is the left button (mask bit 0x04), 1 is the middle button (0x02) and 2 is the right button (0x01). `btn_down`=1 sets the bit and `btn_down`=0 clears it. `btn_sel`=3 is ignored: it changes neither the mask nor the change flag.
- R7: The X and Y amounts sent are the accumulator values clamped to -127..+127. The amount sent is subtracted from the accumulator, and the rest carries into later packets.
- R8: A supported button event sets the change flag, and emitting a packet clears it. Button or motion events in the same cycle as an accepted sync count toward the next packet.
- R9: The FIFO holds FIFO_DEPTH bytes (default 16) and keeps their order. A byte written while the FIFO is full is dropped. A byte leaves when `out_valid` and `out_ready` are both high.
- R10: After the edge that samples an accepted sync, packet byte k enters the FIFO on the (k+1)-th following edge. A sync that arrives while a packet is still being written is ignored and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mot_valid | input | 1 | Motion event strobe |
| mot_axis | input | 1 | Axis of the motion event: 0 = X, 1 = Y |
| mot_delta | input | DELTA_W | Signed motion delta |
| btn_valid | input | 1 | Button event strobe |
| btn_sel | input | 2 | Button select: 0 left, 1 middle, 2 right, 3 none |
| btn_down | input | 1 | 1 = pressed, 0 = released |
| sync | input | 1 | Request to emit a packet |
| out_valid | output | 1 | FIFO holds at least one byte |
| out_data | output | 8 | Byte at the FIFO head |
| out_ready | input | 1 | Consumer takes the head byte |

## Verification
Events change the accumulators, mask and flag on the edge that samples them. A byte written to the FIFO shows on `out_valid`/`out_data` right after that edge, so the start byte of a packet is visible two edges after its sync is driven, and one further byte lands on each following edge. A pop is seen on the next edge. The bench keeps a cycle-stepped reference model of the accumulators, the packet writer and the FIFO contents. Between edges it compares `out_valid` and the head byte with the model on every cycle, so a byte that shows up one cycle early or late, or in the wrong order, is reported. Directed sequences cover the clamp and its carry, saturation, ignored buttons, overflow drops, and syncs that fall while a packet is still being written. Random event mixes from a fixed seed fill the rest.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int BYTE_W  = 8;
  localparam int PKT_LEN = 5;
  localparam int MAG_LIM = 127;
  localparam int NUM_BTN = 3;
  localparam logic [BYTE_W-1:0] HDR_BASE = 8'h87;

  typedef enum logic [1:0] {
    BTN_L = 2'd0,
    BTN_M = 2'd1,
    BTN_R = 2'd2,
    BTN_X = 2'd3
  } btn_sel_e;
endpackage

// File: rtl/mpe_axis_acc.sv
module mpe_axis_acc
  import mpe_pkg::*;
#(
  parameter int ACC_W   = 12,
  parameter int DELTA_W = 8,
  parameter bit INVERT  = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     add_en,
  input  logic signed [DELTA_W-1:0] delta,
  input  logic                     take_en,
  output logic [BYTE_W-1:0]        take,
  output logic                     nonzero
);
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] ACC_HI = SUM_W'((2 ** (ACC_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] ACC_LO = -ACC_HI - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] LIM    = SUM_W'(MAG_LIM);

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] acc_n;
  logic signed [SUM_W-1:0] acc_x, add_x, take_x, sum;

  always_comb begin
    acc_x = {{2{acc[ACC_W-1]}}, acc};
    if (acc_x > LIM)       take_x = LIM;
    else if (acc_x < -LIM) take_x = -LIM;
    else                   take_x = acc_x;
    add_x = {{(SUM_W-DELTA_W){delta[DELTA_W-1]}}, delta};
    if (INVERT) add_x = -add_x;
    if (!add_en) add_x = '0;
    sum = acc_x - (take_en ? take_x : '0) + add_x;
    if (sum > ACC_HI)      acc_n = ACC_HI[ACC_W-1:0];
    else if (sum < ACC_LO) acc_n = ACC_LO[ACC_W-1:0];
    else                   acc_n = sum[ACC_W-1:0];
  end

  assign take    = take_x[BYTE_W-1:0];
  assign nonzero = |acc;

  always_ff @(posedge clk) begin
    if (rst)                  acc <= '0;
    else if (add_en || take_en) acc <= acc_n;
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!add_en && !take_en) |=> $stable(acc)); // R2
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
    (!take_en && add_en && acc == ACC_HI[ACC_W-1:0] && add_x > 0) |=> (acc == ACC_HI[ACC_W-1:0])); // R3
endmodule

// File: rtl/mpe_btn_state.sv
module mpe_btn_state
  import mpe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid,
  input  logic [1:0]         ev_sel,
  input  logic               ev_down,
  input  logic               clr_chg,
  output logic [NUM_BTN-1:0] mask,
  output logic               chg
);
  logic known;
  assign known = ev_valid && (ev_sel != 2'(BTN_X));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      chg  <= 1'b0;
    end else begin
      for (int b = 0; b < NUM_BTN; b++) begin
        if (known && ev_sel == 2'(NUM_BTN - 1 - b)) mask[b] <= ev_down;
      end
      if (known)        chg <= 1'b1;
      else if (clr_chg) chg <= 1'b0;
    end
  end

  AST_CHG_SET: assert property (@(posedge clk) disable iff (rst)
    known |=> chg); // R8
  AST_CHG_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr_chg && !known) |=> !chg); // R8
  AST_SEL_NONE: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_sel == 2'(BTN_X)) |=> $stable(mask)); // R6
endmodule

// File: rtl/mpe_packer.sv
module mpe_packer
  import mpe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sync,
  input  logic               has_data,
  input  logic [NUM_BTN-1:0] mask,
  input  logic [BYTE_W-1:0]  x_take,
  input  logic [BYTE_W-1:0]  y_take,
  output logic               fire,
  output logic               wr_en,
  output logic [BYTE_W-1:0]  wr_data
);
  localparam int IDX_W = $clog2(PKT_LEN);

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] hdr_q, x_q, y_q;

  assign fire  = sync && !busy && has_data;
  assign wr_en = busy;

  always_comb begin
    case (idx)
      IDX_W'(0): wr_data = hdr_q;
      IDX_W'(1): wr_data = x_q;
      IDX_W'(2): wr_data = y_q;
      default:   wr_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      idx   <= '0;
      hdr_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
    end else if (fire) begin
      busy  <= 1'b1;
      idx   <= '0;
      hdr_q <= HDR_BASE ^ BYTE_W'(mask);
      x_q   <= x_take;
      y_q   <= y_take;
    end else if (busy) begin
      idx <= idx + IDX_W'(1);
      if (idx == IDX_W'(PKT_LEN - 1)) busy <= 1'b0;
    end
  end

  AST_QUIET_SYNC: assert property (@(posedge clk) disable iff (rst)
    (sync && !busy && !has_data) |=> !wr_en); // R4
  AST_NO_M128: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (idx == IDX_W'(1) || idx == IDX_W'(2))) |-> (wr_data != 8'h80)); // R7
  AST_HDR_FORM: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == '0) |-> (wr_data[7:3] == 5'b10000)); // R5
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx < IDX_W'(PKT_LEN))); // R10
endmodule

// File: rtl/mpe_fifo.sv
module mpe_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  input  logic         rd_ready
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = AW + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             push, pop;

  assign rd_valid = (count != '0);
  assign push     = wr_en && (count != CNT_W'(DEPTH));
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && count == CNT_W'(DEPTH) && !rd_ready) |=> (count == $past(count))); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> (count <= CNT_W'(1))); // R9
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int DELTA_W    = 8,
  parameter int ACC_W      = 12,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mot_valid,
  input  logic                      mot_axis,
  input  logic signed [DELTA_W-1:0] mot_delta,
  input  logic                      btn_valid,
  input  logic [1:0]                btn_sel,
  input  logic                      btn_down,
  input  logic                      sync,
  output logic                      out_valid,
  output logic [BYTE_W-1:0]         out_data,
  input  logic                      out_ready
);
  logic [1:0]         ax_nz;
  logic [BYTE_W-1:0]  ax_take [2];
  logic [NUM_BTN-1:0] mask;
  logic               chg, fire, wr_en;
  logic [BYTE_W-1:0]  wr_data;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    mpe_axis_acc #(
      .ACC_W  (ACC_W),
      .DELTA_W(DELTA_W),
      .INVERT (a == 1)
    ) u_acc (
      .clk    (clk),
      .rst    (rst),
      .add_en (mot_valid && (mot_axis == 1'(a))),
      .delta  (mot_delta),
      .take_en(fire),
      .take   (ax_take[a]),
      .nonzero(ax_nz[a])
    );
  end

  mpe_btn_state u_btn (
    .clk     (clk),
    .rst     (rst),
    .ev_valid(btn_valid),
    .ev_sel  (btn_sel),
    .ev_down (btn_down),
    .clr_chg (fire),
    .mask    (mask),
    .chg     (chg)
  );

  mpe_packer u_pack (
    .clk     (clk),
    .rst     (rst),
    .sync    (sync),
    .has_data((|ax_nz) || chg),
    .mask    (mask),
    .x_take  (ax_take[0]),
    .y_take  (ax_take[1]),
    .fire    (fire),
    .wr_en   (wr_en),
    .wr_data (wr_data)
  );

  mpe_fifo #(
    .DEPTH(FIFO_DEPTH),
    .W    (BYTE_W)
  ) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_valid(out_valid),
    .rd_data (out_data),
    .rd_ready(out_ready)
  );

  AST_RST_EMPTY: assert property (@(posedge clk)
    rst |=> !out_valid); // R1
endmodule

// File: tb/mouse_pkt_enc_tb.sv
module mouse_pkt_enc_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mot_valid = 1'b0, mot_axis = 1'b0;
  logic signed [7:0] mot_delta = '0;
  logic btn_valid = 1'b0, btn_down = 1'b0, sync = 1'b0, out_ready = 1'b0;
  logic [1:0] btn_sel = '0;
  logic out_valid;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  mouse_pkt_enc dut_i (
    .clk(clk), .rst(rst), .mot_valid(mot_valid), .mot_axis(mot_axis),
    .mot_delta(mot_delta), .btn_valid(btn_valid), .btn_sel(btn_sel),
    .btn_down(btn_down), .sync(sync), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // reference model
  int m_ax = 0, m_ay = 0, m_mask = 0, m_chg = 0, m_cnt = 0;
  int m_pkt [5];
  int q [$];

  function automatic int sat12(int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int clamp127(int v);
    if (v > 127) return 127;
    if (v < -127) return -127;
    return v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit sy, bit mv, bit ax, int d, bit bv, int id, bit dn, bit rdy);
    int fire, tx, ty, qn, pop;
    // compare outputs with the model between edges (R10 timing, R9 order)
    if (q.size() > 0) chk(out_valid && out_data == 8'(q[0]), cur_req, {out_valid, out_data}, 256 | q[0]);
    else chk(!out_valid, cur_req, out_valid, 0);
    sync = sy; mot_valid = mv; mot_axis = ax; mot_delta = 8'(d);
    btn_valid = bv; btn_sel = 2'(id); btn_down = dn; out_ready = rdy;
    @(posedge clk);
    qn  = q.size();
    pop = (rdy && qn > 0);
    fire = sy && (m_cnt == 0) && (m_ax != 0 || m_ay != 0 || m_chg != 0);
    if (pop) void'(q.pop_front());
    if (m_cnt > 0) begin
      if (qn < DEPTH) q.push_back(m_pkt[5 - m_cnt]);
      m_cnt--;
    end
    tx = fire ? clamp127(m_ax) : 0;
    ty = fire ? clamp127(m_ay) : 0;
    if (fire) begin
      m_pkt[0] = 8'h87 ^ m_mask;
      m_pkt[1] = tx & 255;
      m_pkt[2] = ty & 255;
      m_pkt[3] = 0;
      m_pkt[4] = 0;
      m_cnt = 5;
    end
    m_ax = sat12(m_ax - tx + ((mv && !ax) ? d : 0));
    m_ay = sat12(m_ay - ty - ((mv && ax) ? d : 0));
    if (bv && id != 3) begin
      if (dn) m_mask = m_mask | (1 << (2 - id));
      else    m_mask = m_mask & ~(1 << (2 - id));
      m_chg = 1;
    end else if (fire) m_chg = 0;
    @(negedge clk);
    sync = 1'b0; mot_valid = 1'b0; btn_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic move(bit ax, int d);
    step(0, 1, ax, d, 0, 0, 0, 0);
  endtask
  task automatic btn(int id, bit dn);
    step(0, 0, 0, 0, 1, id, dn, 0);
  endtask
  task automatic pkt();
    step(1, 0, 0, 0, 0, 0, 0, 0);
    idle(6);
  endtask
  task automatic drain();
    for (int i = 0; i < 2 * DEPTH && q.size() > 0; i++) step(0, 0, 0, 0, 0, 0, 0, 1);
    idle(1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    chk(!out_valid, "R1", out_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    chk(!out_valid, "R1", out_valid, 0);
    // R1 / R4: sync straight after reset writes nothing
    cur_req = "R4";
    pkt();
    chk(q.size() == 0 && !out_valid, "R4", out_valid, 0);

    // R2 / R5: basic packet, Y inverted
    cur_req = "R5";
    move(0, 5); move(1, 3);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    chk(!out_valid, "R10", out_valid, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk(out_valid && out_data == 8'h87, "R10", out_data, 8'h87);
    idle(5);
    chk(q.size() == 5 && q[1] == 8'h05 && q[2] == 8'hFD, "R2", q[2], 8'hFD);
    drain();

    // R6: buttons active-low in the start byte, sel 3 ignored
    cur_req = "R6";
    btn(0, 1); pkt();
    chk(q.size() == 5 && q[0] == 8'h83, "R6", q[0], 8'h83);
    drain();
    btn(1, 1); btn(2, 1); pkt();
    chk(q[0] == 8'h80, "R6", q[0], 8'h80);
    drain();
    btn(3, 1); pkt();
    chk(q.size() == 0, "R6", q.size(), 0);
    btn(0, 0); btn(1, 0); btn(2, 0); pkt(); drain();

    // R7: clamp and carry of 300
    cur_req = "R7";
    move(0, 100); move(0, 100); move(0, 100);
    pkt(); chk(q[1] == 127, "R7", q[1], 127); drain();
    pkt(); chk(q[1] == 127, "R7", q[1], 127); drain();
    pkt(); chk(q[1] == 46, "R7", q[1], 46); drain();
    pkt(); chk(q.size() == 0, "R7", q.size(), 0);

    // R3: saturate at +2047 on Y (negative deltas), then empty it
    cur_req = "R3";
    for (int i = 0; i < 20; i++) move(1, -128);
    chk(m_ay == 2047, "R3", m_ay, 2047);
    for (int i = 0; i < 17; i++) begin pkt(); drain(); end
    pkt();
    chk(q.size() == 0 && m_ay == 0, "R3", m_ay, 0);
    for (int i = 0; i < 20; i++) move(0, -128);
    chk(m_ax == -2048, "R3", m_ax, -2048);
    for (int i = 0; i < 18; i++) begin pkt(); drain(); end

    // R9: overflow drops tail bytes
    cur_req = "R9";
    for (int i = 0; i < 4; i++) begin move(0, i + 1); pkt(); end
    chk(q.size() == DEPTH, "R9", q.size(), DEPTH);
    drain();

    // R10: sync while writing is ignored
    cur_req = "R10";
    move(0, 9);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 4, 0, 0, 0, 0);
    idle(6);
    chk(q.size() == 5, "R10", q.size(), 5);
    drain();
    pkt(); chk(q.size() == 5 && q[1] == 4, "R10", q[1], 4); drain();

    // R8: events in the same cycle as sync go to the next packet
    cur_req = "R8";
    move(1, 2);
    step(1, 1, 0, 7, 1, 2, 1, 0);
    idle(6);
    chk(q[0] == 8'h87, "R8", q[0], 8'h87);
    drain();
    pkt(); chk(q[0] == 8'h86 && q[1] == 7, "R8", q[0], 8'h86); drain();
    pkt(); chk(q.size() == 0, "R8", q.size(), 0);

    // random mix
    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom_range(9));
      if (op < 4) move(1'($urandom_range(1)), int'($urandom_range(255)) - 128);
      else if (op < 6) btn(int'($urandom_range(3)), 1'($urandom_range(1)));
      else if (op < 8) step(1'($urandom_range(1)), 0, 0, 0, 0, 0, 0, 1'($urandom_range(1)));
      else step(0, 0, 0, 0, 0, 0, 0, 1);
    end
    idle(6);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=%0d exp=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule